// File: doc/BRIEF.md
# Periodic Tick and Square-Wave Rate Generator

This block turns a 32768 Hz time-base strobe into a periodic tick and a square wave, both at one of fifteen fixed power-of-two rates picked by a 4-bit rate code. Code 0 turns both outputs off. Each completed period produces a one-cycle tick pulse, which the neighbouring interrupt logic uses to set its periodic flag. A second pulse, qualified by the periodic-interrupt enable, is the request. A separate enable gates the square-wave pin.

The rate code is bits 3:0 of control register A. The square-wave enable is bit 3 of control register B, and the periodic-interrupt enable is bit 6 of control register B. The block takes these bits as separate inputs. A divider-hold input stands for the divider-reset state of register A. While it is asserted, the divider is cleared and both outputs stay quiet.

A new rate code is adopted only when the running period rolls over, so no period is ever cut short or stretched. If the generator is idle (code 0), a new nonzero code is adopted on the next time-base strobe.

Top module: `ptick_gen`

## Requirements
- R1: With rate code 0 (control A bits 3:0 = 0), `per_tick`, `per_req` and `sq_wave` stay low.
- R2: The period, counted in time-base strobes, is 128 for code 1, 256 for code 2, and 2^(code-1) for codes 3 to 15. Code 3 gives 4 strobes (8192 Hz) and code 15 gives 16384 strobes (2 Hz).
- R3: The divider advances only on clock cycles where `base_tick` is high. With strobes every third clock, code 3 yields a tick every 12 clocks.
- R4: When `sq_enable` (control B bit 3) is high, `sq_wave` is high for exactly half of every period. When `sq_enable` is low, `sq_wave` stays low and the tick period does not change.
- R5: `per_tick` is a one-cycle pulse, issued once per period whatever the value of `pi_enable`.
- R6: `per_req` pulses together with `per_tick` only when `pi_enable` (control B bit 6) is high. Otherwise it stays low.
- R7: A rate code change made in mid-period takes effect at the next rollover. The running period completes at the old length, and the period after it has the new length.
- R8: While `div_hold` is high, `per_tick`, `per_req` and `sq_wave` are low. After release, the first tick comes on the P-th strobe, where P is the period of the current code.
- R9: After `rst_n` goes low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | One-cycle strobe at the 32768 Hz time-base rate |
| rate_sel | input | 4 | Rate code (control A bits 3:0) |
| sq_enable | input | 1 | Square-wave output enable (control B bit 3) |
| pi_enable | input | 1 | Periodic interrupt enable (control B bit 6) |
| div_hold | input | 1 | Divider held in reset |
| sq_wave | output | 1 | Square-wave output |
| per_tick | output | 1 | One-cycle pulse per period, used to set the periodic flag |
| per_req | output | 1 | Periodic tick qualified by the interrupt enable |

## Verification
The bench targets the irregular mapping of the two fastest codes. A design that treated codes 1 and 2 like the others would give periods of 1 and 2 strobes instead of 128 and 256. The bench also changes the rate code in mid-period: a design that tapped a shared counter directly would produce one truncated or stretched period instead of finishing the old one. It runs with the interrupt enable cleared, which exposes a design that suppresses the flag pulse instead of only the request. Finally, it checks the first period after a divider hold, which catches a divider that does not restart from zero.

// File: rtl/ptick_pkg.sv
package ptick_pkg;
    localparam int unsigned CODE_W = 4;
    localparam int unsigned CNT_W  = 14;

    typedef struct packed {
        logic [CODE_W-1:0] act;
        logic [CNT_W-1:0]  cnt;
        logic              sqw;
        logic              tick;
        logic              req;
    } ptick_state_t;
endpackage

// File: rtl/ptick_rate_map.sv
module ptick_rate_map #(
    parameter int unsigned CODE_W = 4,
    parameter int unsigned CNT_W  = 14,
    parameter int unsigned EXP_C1 = 7,
    parameter int unsigned EXP_C2 = 8
) (
    input  logic [CODE_W-1:0] code,
    output logic              on,
    output logic [CNT_W-1:0]  last_cnt,
    output logic [CNT_W-1:0]  half_bit
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    int unsigned expo;

    always_comb begin
        if (code == CODE_W'(1))      expo = EXP_C1;
        else if (code == CODE_W'(2)) expo = EXP_C2;
        else if (code == '0)         expo = 1;
        else                         expo = 32'(code) - 1;
        if (expo > CNT_W) expo = CNT_W;
        on       = (code != '0);
        last_cnt = ALL_ONES >> (CNT_W - expo);
        half_bit = CNT_W'(1) << (expo - 1);
    end
endmodule

// File: rtl/ptick_core.sv
module ptick_core
    import ptick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic [CODE_W-1:0] rate_sel,
    input  logic              sq_enable,
    input  logic              pi_enable,
    input  logic              div_hold,
    input  logic              map_on,
    input  logic [CNT_W-1:0]  map_last,
    input  logic [CNT_W-1:0]  map_half,
    output logic [CODE_W-1:0] act_code,
    output logic              sq_wave,
    output logic              per_tick,
    output logic              per_req
);
    ptick_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        st_d.req  = 1'b0;
        // wave level follows the state of the previous cycle
        st_d.sqw  = !div_hold && sq_enable && map_on && (|(st_q.cnt & map_half));
        if (div_hold) begin
            st_d.act = rate_sel;
            st_d.cnt = '0;
        end else if (base_tick) begin
            if (!map_on) begin
                st_d.act = rate_sel;
                st_d.cnt = '0;
            end else if (st_q.cnt == map_last) begin
                st_d.cnt  = '0;
                st_d.act  = rate_sel;
                st_d.tick = 1'b1;
                st_d.req  = pi_enable;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_code = st_q.act;
    assign sq_wave  = st_q.sqw;
    assign per_tick = st_q.tick;
    assign per_req  = st_q.req;
endmodule

// File: rtl/ptick_gen.sv
module ptick_gen
    import ptick_pkg::*;
#(
    parameter int unsigned EXP_C1 = 7,
    parameter int unsigned EXP_C2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic [CODE_W-1:0] rate_sel,
    input  logic              sq_enable,
    input  logic              pi_enable,
    input  logic              div_hold,
    output logic              sq_wave,
    output logic              per_tick,
    output logic              per_req
);
    logic [CODE_W-1:0] act_code;
    logic              map_on;
    logic [CNT_W-1:0]  map_last;
    logic [CNT_W-1:0]  map_half;

    ptick_rate_map #(
        .CODE_W(CODE_W), .CNT_W(CNT_W), .EXP_C1(EXP_C1), .EXP_C2(EXP_C2)
    ) map_i (
        .code(act_code), .on(map_on), .last_cnt(map_last), .half_bit(map_half)
    );

    ptick_core core_i (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .rate_sel(rate_sel),
        .sq_enable(sq_enable), .pi_enable(pi_enable), .div_hold(div_hold),
        .map_on(map_on), .map_last(map_last), .map_half(map_half),
        .act_code(act_code), .sq_wave(sq_wave), .per_tick(per_tick), .per_req(per_req)
    );
endmodule

// File: rtl/ptick_gen_chk.sv
module ptick_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic base_tick,
    input logic sq_enable,
    input logic pi_enable,
    input logic div_hold,
    input logic sq_wave,
    input logic per_tick,
    input logic per_req
);
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick |=> !per_tick);                                         // R5
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !pi_enable |=> !per_req);                                        // R6
    AST_REQ_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        per_req |-> per_tick);                                           // R6
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        div_hold |=> (!sq_wave && !per_tick && !per_req));               // R8
    AST_NO_STROBE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !base_tick |=> !per_tick);                                       // R3
    AST_WAVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_enable |=> !sq_wave);                                        // R4
endmodule

bind ptick_gen ptick_gen_chk chk_i (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .sq_enable(sq_enable),
    .pi_enable(pi_enable), .div_hold(div_hold), .sq_wave(sq_wave),
    .per_tick(per_tick), .per_req(per_req)
);

// File: tb/ptick_gen_tb_top.sv
module ptick_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic [3:0] rate_sel = '0;
    logic       sq_enable = 1'b0;
    logic       pi_enable = 1'b0;
    logic       div_hold = 1'b0;
    logic       sq_wave, per_tick, per_req;

    int checks = 0;
    int errors = 0;
    int strobe_div = 1;
    int ph = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ptick_gen dut_i (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .rate_sel(rate_sel),
        .sq_enable(sq_enable), .pi_enable(pi_enable), .div_hold(div_hold),
        .sq_wave(sq_wave), .per_tick(per_tick), .per_req(per_req)
    );

    // strobe generator: one strobe every strobe_div clocks
    always @(negedge clk) begin
        if (!rst_n) begin
            ph = 0;
            base_tick <= 1'b0;
        end else begin
            base_tick <= (ph == 0);
            ph = (ph + 1 >= strobe_div) ? 0 : ph + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // waits for a tick, then measures clocks to the next one
    task automatic measure(output int len, output int hi, output int reqs);
        int guard = 0;
        len = 0; hi = 0; reqs = 0;
        while (!per_tick && guard < 70000) begin step(); guard++; end
        do begin
            step();
            len++;
            if (sq_wave) hi++;
            if (per_req) reqs++;
        end while (!per_tick && len < 70000);
    endtask

    task automatic retime(input logic [3:0] code);
        rate_sel = code;
        div_hold = 1'b1;
        step();
        div_hold = 1'b0;
    endtask

    task automatic t_reset();
        step();
        check(!sq_wave && !per_tick && !per_req, "R9", {sq_wave, per_tick, per_req}, 0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_code_zero();
        int seen = 0;
        rate_sel = 4'd0; sq_enable = 1'b1; pi_enable = 1'b1;
        for (int i = 0; i < 400; i++) begin
            step();
            if (sq_wave || per_tick || per_req) seen++;
        end
        check(seen == 0, "R1", seen, 0);
    endtask

    task automatic t_period(input logic [3:0] code, input int exp);
        int len, hi, reqs;
        sq_enable = 1'b1; pi_enable = 1'b1;
        retime(code);
        measure(len, hi, reqs);
        check(len == exp, $sformatf("R2 code %0d", code), len, exp);
        check(hi == exp / 2, $sformatf("R4 code %0d", code), hi, exp / 2);
        check(reqs == 1, $sformatf("R6 code %0d", code), reqs, 1);
    endtask

    task automatic t_pie_off();
        int len, hi, reqs;
        pi_enable = 1'b0; sq_enable = 1'b1;
        retime(4'd4);
        measure(len, hi, reqs);
        check(len == 8, "R5 tick without enable", len, 8);
        check(reqs == 0, "R6 request masked", reqs, 0);
    endtask

    task automatic t_sqw_off();
        int len, hi, reqs;
        pi_enable = 1'b1; sq_enable = 1'b0;
        retime(4'd5);
        measure(len, hi, reqs);
        check(len == 16, "R4 period kept", len, 16);
        check(hi == 0, "R4 wave off", hi, 0);
    endtask

    task automatic t_base_rate();
        int len, hi, reqs;
        sq_enable = 1'b1; pi_enable = 1'b1;
        strobe_div = 3;
        retime(4'd3);
        measure(len, hi, reqs);
        check(len == 12, "R3 strobe gating", len, 12);
        strobe_div = 1;
        step(); step(); step();
    endtask

    task automatic t_rate_change();
        int len, hi, reqs;
        sq_enable = 1'b1; pi_enable = 1'b1;
        retime(4'd6);
        measure(len, hi, reqs);
        for (int i = 0; i < 5; i++) step();
        rate_sel = 4'd3;
        len = 5;
        while (!per_tick && len < 1000) begin step(); len++; end
        check(len == 32, "R7 old period completes", len, 32);
        len = 0;
        do begin step(); len++; end while (!per_tick && len < 1000);
        check(len == 4, "R7 new period", len, 4);
    endtask

    task automatic t_div_hold();
        int seen = 0;
        int n = 0;
        sq_enable = 1'b1; pi_enable = 1'b1;
        rate_sel = 4'd5;
        div_hold = 1'b1;
        for (int i = 0; i < 40; i++) begin
            step();
            if (sq_wave || per_tick || per_req) seen++;
        end
        check(seen == 0, "R8 held low", seen, 0);
        div_hold = 1'b0;
        do begin step(); n++; end while (!per_tick && n < 1000);
        check(n == 16, "R8 first tick after release", n, 16);
    endtask

    initial begin
        t_reset();
        t_code_zero();
        t_period(4'd3, 4);
        t_period(4'd7, 64);
        t_period(4'd1, 128);
        t_period(4'd2, 256);
        t_pie_off();
        t_sqw_off();
        t_base_rate();
        t_rate_change();
        t_div_hold();
        t_period(4'd15, 16384);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule